// File: doc/BRIEF.md
# Two-Entry Translation Lookaside Buffer

This block translates a 4-bit virtual page number into an 8-bit physical page number. It caches two translations in a pair of fully associative slots, with a single recency bit choosing which slot to replace. With a 12-bit virtual address and 256-byte pages, the page number is the upper four address bits. The caller supplies those bits only; the byte offset never enters the block.

When neither slot matches, the block reads a flat page table of sixteen entries that it keeps in its own registers. Each table entry holds a valid flag and a physical page number, and the result arrives a fixed number of cycles after the lookup. A valid entry is copied into the slot chosen for replacement and returned. An invalid entry is returned as a fault and nothing is cached. A load port fills the table before use.

During a table fetch the block raises a busy output and ignores any lookup presented to it. The caller must keep presenting a lookup until it gets a response.

Top module: `tlb2_top`

## Requirements
- R1: After reset, busy and rsp_valid are low, both slots are empty so the first lookup of any page misses, and every page-table entry is invalid.
- R2: A lookup that matches a cached page, while busy is low, raises rsp_valid and rsp_hit in the same cycle, with rsp_fault low and rsp_ppn equal to the cached physical page.
- R3: A lookup that matches no slot gives no response in its own cycle. Busy is high from the next cycle through the response cycle. The response, with rsp_hit low, comes exactly MISS_LAT (default 25) cycles after the lookup cycle, and busy is low in the cycle after it.
- R4: A miss whose table entry is valid returns that entry's physical page with rsp_fault low and caches it, so the next lookup of that page hits.
- R5: A miss whose table entry is invalid returns rsp_fault high with rsp_hit low, caches nothing, and leaves the recency state unchanged.
- R6: The slot replaced on a fill is an empty slot if there is one, otherwise the least recently used slot. Both a hit and a fill make their slot the most recently used.
- R7: A lookup presented while busy is high gets no response and changes no cached entry or recency state.
- R8: A page-table write (pt_wr_en high) at a clock edge sets the entry at pt_wr_vpn to pt_wr_valid and pt_wr_ppn, and later misses on that page use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_wr_en | input | 1 | Page-table write strobe |
| pt_wr_vpn | input | 4 | Page-table entry to write |
| pt_wr_valid | input | 1 | Valid flag to store |
| pt_wr_ppn | input | 8 | Physical page to store |
| req_valid | input | 1 | Lookup request present |
| req_vpn | input | 4 | Virtual page to translate |
| busy | output | 1 | Table fetch in progress; lookups ignored |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Response came from a cached slot |
| rsp_fault | output | 1 | Table entry for the page is invalid |
| rsp_ppn | output | 8 | Translated physical page |

## Verification
The case that is hardest to reach from the ports is a full slot pair whose recency bit has just been flipped by a hit, followed by a fault that must leave the bit as it was. Only the choice of victim on a later fill can show that bit. The vector table therefore runs a hit, then a fault, then two misses in a row, so a recency bit that was disturbed evicts the wrong page and a later expected hit turns into a miss. Every fetch also presents a lookup that would hit, one per busy cycle, to show that lookups during a fetch have no effect.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  localparam int unsigned VPN_BITS = 4;
  localparam int unsigned PPN_BITS = 8;
  localparam int unsigned FETCH_CYCLES = 25;

  // slot to overwrite: first empty one, else the least recently used
  function automatic logic pick_victim(input logic [1:0] occ, input logic lru_slot);
    if (!occ[0]) return 1'b0;
    if (!occ[1]) return 1'b1;
    return lru_slot;
  endfunction

  // the other slot becomes least recently used once 'used' is touched
  function automatic logic next_lru(input logic used);
    return ~used;
  endfunction
endpackage

// File: rtl/tlb2_ptab.sv
module tlb2_ptab #(
  parameter int unsigned VPN_W = 4,
  parameter int unsigned PPN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_valid,
  output logic [PPN_W-1:0] rd_ppn
);
  localparam int unsigned DEPTH = 1 << VPN_W;

  logic             ent_vld [DEPTH];
  logic [PPN_W-1:0] ent_ppn [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_vld[i] <= 1'b0;
        ent_ppn[i] <= '0;
      end
    end else if (wr_en) begin
      ent_vld[wr_vpn] <= wr_valid;
      ent_ppn[wr_vpn] <= wr_ppn;
    end
  end

  assign rd_valid = ent_vld[rd_vpn];
  assign rd_ppn   = ent_ppn[rd_vpn];
endmodule

// File: rtl/tlb2_slots.sv
module tlb2_slots
  import tlb2_pkg::*;
#(
  parameter int unsigned VPN_W = 4,
  parameter int unsigned PPN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             touch_en,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  localparam int unsigned SLOTS = 2;

  logic [SLOTS-1:0] occ;
  logic [VPN_W-1:0] tag [SLOTS];
  logic [PPN_W-1:0] dat [SLOTS];
  logic             lru;
  logic [SLOTS-1:0] match;
  logic             hit_slot;
  logic             victim;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = occ[g] && (tag[g] == lk_vpn);
  end

  assign hit      = |match;
  assign hit_slot = match[1];
  assign hit_ppn  = hit_slot ? dat[1] : dat[0];
  assign victim   = pick_victim(occ, lru);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      lru <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        tag[i] <= '0;
        dat[i] <= '0;
      end
    end else if (fill_en) begin
      occ[victim] <= 1'b1;
      tag[victim] <= fill_vpn;
      dat[victim] <= fill_ppn;
      lru         <= next_lru(victim);
    end else if (touch_en) begin
      lru <= next_lru(hit_slot);
    end
  end
endmodule

// File: rtl/tlb2_fetch.sv
module tlb2_fetch #(
  parameter int unsigned VPN_W    = 4,
  parameter int unsigned MISS_LAT = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  output logic             busy,
  output logic             done,
  output logic [VPN_W-1:0] fetch_vpn
);
  localparam int unsigned CNT_W = $clog2(MISS_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MISS_LAT - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remain    <= '0;
      fetch_vpn <= '0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        remain    <= CNT_LOAD;
        fetch_vpn <= start_vpn;
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  assign done = busy && (remain == '0);
endmodule

// File: rtl/tlb2_top.sv
module tlb2_top
  import tlb2_pkg::*;
#(
  parameter int unsigned VPN_W    = VPN_BITS,
  parameter int unsigned PPN_W    = PPN_BITS,
  parameter int unsigned MISS_LAT = FETCH_CYCLES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pt_wr_en,
  input  logic [VPN_W-1:0] pt_wr_vpn,
  input  logic             pt_wr_valid,
  input  logic [PPN_W-1:0] pt_wr_ppn,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PPN_W-1:0] rsp_ppn
);
  logic             lk_go, slot_hit, hit_fire, miss_fire;
  logic [PPN_W-1:0] slot_ppn;
  logic             fetch_done;
  logic [VPN_W-1:0] fetch_vpn;
  logic             pte_valid;
  logic [PPN_W-1:0] pte_ppn;
  logic             fill_en;

  assign lk_go     = req_valid && !busy;
  assign hit_fire  = lk_go && slot_hit;
  assign miss_fire = lk_go && !slot_hit;
  assign fill_en   = fetch_done && pte_valid;

  tlb2_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ptab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pt_wr_en), .wr_vpn(pt_wr_vpn), .wr_valid(pt_wr_valid), .wr_ppn(pt_wr_ppn),
    .rd_vpn(fetch_vpn), .rd_valid(pte_valid), .rd_ppn(pte_ppn)
  );

  tlb2_slots #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vpn), .touch_en(hit_fire),
    .fill_en(fill_en), .fill_vpn(fetch_vpn), .fill_ppn(pte_ppn),
    .hit(slot_hit), .hit_ppn(slot_ppn)
  );

  tlb2_fetch #(.VPN_W(VPN_W), .MISS_LAT(MISS_LAT)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(miss_fire), .start_vpn(req_vpn),
    .busy(busy), .done(fetch_done), .fetch_vpn(fetch_vpn)
  );

  assign rsp_valid = hit_fire || fetch_done;
  assign rsp_hit   = hit_fire;
  assign rsp_fault = fetch_done && !pte_valid;
  assign rsp_ppn   = hit_fire ? slot_ppn : (fill_en ? pte_ppn : '0);
endmodule

// File: rtl/tlb2_chk.sv
module tlb2_chk #(
  parameter int unsigned MISS_LAT = 25
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_fault
);
  localparam int unsigned RUN_W = $clog2(MISS_LAT + 1) + 1;
  logic [RUN_W-1:0] busy_run;
  logic             at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  assign at_end = (busy_run == RUN_W'(MISS_LAT - 1));

  AST_HIT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !busy); // R2
  AST_IDLE_RSP_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !busy) |-> (rsp_hit && !rsp_fault)); // R2
  AST_MISS_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !rsp_valid) |=> busy); // R3
  AST_FETCH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && busy) |-> at_end); // R3
  AST_BUSY_ENDS_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rsp_valid)); // R3
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_end) |-> !rsp_valid); // R7
  AST_FAULT_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && !rsp_hit)); // R5
endmodule

bind tlb2_top tlb2_chk #(.MISS_LAT(MISS_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault)
);

// File: tb/test_tlb2_top.sv
module test_tlb2_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 25;
  localparam int NVEC = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pt_wr_en = 1'b0;
  logic [3:0] pt_wr_vpn = '0;
  logic       pt_wr_valid = 1'b0;
  logic [7:0] pt_wr_ppn = '0;
  logic       req_valid = 1'b0;
  logic [3:0] req_vpn = '0;
  logic       busy, rsp_valid, rsp_hit, rsp_fault;
  logic [7:0] rsp_ppn;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb2_top i_tlb2_top (
    .clk(clk), .rst_n(rst_n),
    .pt_wr_en(pt_wr_en), .pt_wr_vpn(pt_wr_vpn), .pt_wr_valid(pt_wr_valid), .pt_wr_ppn(pt_wr_ppn),
    .req_valid(req_valid), .req_vpn(req_vpn),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn)
  );

  // {vpn, expect hit, expect fault, expect ppn}
  localparam logic [13:0] VEC [NVEC] = '{
    {4'hc, 1'b0, 1'b0, 8'hba},  // R4 fill empty slot
    {4'h2, 1'b0, 1'b0, 8'h4b},  // R4 fill second slot
    {4'hc, 1'b1, 1'b0, 8'hba},  // R2
    {4'h2, 1'b1, 1'b0, 8'h4b},  // R2, c now least recent
    {4'h1, 1'b0, 1'b0, 8'hfd},  // R6 evicts c
    {4'h0, 1'b0, 1'b1, 8'h00},  // R5
    {4'h2, 1'b1, 1'b0, 8'h4b},  // R6 2 kept
    {4'h0, 1'b0, 1'b1, 8'h00},  // R5 not cached
    {4'hc, 1'b0, 1'b0, 8'hba},  // R6 evicts 1
    {4'h1, 1'b0, 1'b0, 8'hfd},  // R6 evicts 2
    {4'hc, 1'b1, 1'b0, 8'hba},  // R2
    {4'h5, 1'b0, 1'b0, 8'h32},  // R6 evicts 1
    {4'h5, 1'b1, 1'b0, 8'h32},  // R2
    {4'hd, 1'b0, 1'b0, 8'h01},  // R6 evicts c
    {4'hc, 1'b0, 1'b0, 8'hba}   // R6 c was gone
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pt_write(input logic [3:0] v, input logic vld, input logic [7:0] p);
    @(negedge clk);
    pt_wr_en = 1'b1; pt_wr_vpn = v; pt_wr_valid = vld; pt_wr_ppn = p;
    @(negedge clk);
    pt_wr_en = 1'b0;
  endtask

  task automatic load_table();
    pt_write(4'h1, 1'b1, 8'hfd);
    pt_write(4'h2, 1'b1, 8'h4b);
    pt_write(4'h4, 1'b1, 8'h55);
    pt_write(4'h5, 1'b1, 8'h32);
    pt_write(4'h6, 1'b1, 8'h54);
    pt_write(4'h9, 1'b1, 8'hfe);
    pt_write(4'ha, 1'b1, 8'hfc);
    pt_write(4'hc, 1'b1, 8'hba);
    pt_write(4'hd, 1'b1, 8'h01);
  endtask

  task automatic lookup(input logic [3:0] v, input bit ehit, input bit efault,
                        input logic [7:0] eppn, input logic [3:0] noise);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v;
    #(CLK_PERIOD/4);
    if (ehit) begin
      check(rsp_valid && rsp_hit, "R2", "hit response", {rsp_valid, rsp_hit}, 3);
      check(rsp_ppn == eppn, "R2", "hit ppn", rsp_ppn, eppn);
      check(!rsp_fault, "R2", "hit fault", rsp_fault, 0);
    end else begin
      check(!rsp_valid, "R3", "no response in miss cycle", rsp_valid, 0);
      k = 0;
      do begin
        @(negedge clk);
        req_vpn = noise;  // R7: lookups during the fetch are ignored
        k++;
        #(CLK_PERIOD/4);
        check(busy, "R3", "busy during fetch", busy, 1);
      end while (!rsp_valid && k < LAT + 4);
      check(k == LAT, "R3", "fetch latency", k, LAT);
      check(!rsp_hit, "R3", "miss hit flag", rsp_hit, 0);
      check(rsp_fault == efault, efault ? "R5" : "R4", "fault flag", rsp_fault, efault);
      if (!efault) check(rsp_ppn == eppn, "R4", "fetched ppn", rsp_ppn, eppn);
      @(negedge clk);
      req_valid = 1'b0;
      #(CLK_PERIOD/4);
      check(!busy, "R3", "busy cleared after response", busy, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!rsp_valid, "R1", "rsp_valid after reset", rsp_valid, 0);
    load_table();

    for (int i = 0; i < NVEC; i++) begin
      lookup(VEC[i][13:10], VEC[i][9], VEC[i][8], VEC[i][7:0],
             (VEC[i][13:10] == 4'hc) ? 4'h2 : 4'hc);
    end
    @(negedge clk); req_valid = 1'b0;

    // R8: table rewrite seen by a later miss
    pt_write(4'h3, 1'b1, 8'h77);
    lookup(4'h3, 1'b0, 1'b0, 8'h77, 4'h3);
    lookup(4'h3, 1'b1, 1'b0, 8'h77, 4'h3);
    @(negedge clk); req_valid = 1'b0;

    // R1: reset empties slots and table
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check(!busy && !rsp_valid, "R1", "idle after second reset", {busy, rsp_valid}, 0);
    pt_write(4'h5, 1'b1, 8'h32);
    lookup(4'h5, 1'b0, 1'b0, 8'h32, 4'h5);   // R1: was cached before reset, misses now
    lookup(4'h2, 1'b0, 1'b1, 8'h00, 4'h5);   // R1: table entry cleared by reset
    @(negedge clk); req_valid = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule